// File: doc/BRIEF.md
# Stereo Gain Update Controller with Zero-Cross Deferral

This block holds the requested gain for the two channels of a stereo converter. Each channel has an 8-bit gain code in half-decibel steps. The block turns the code into two settings. One is an analogue preamplifier code. The other is a post-converter digital attenuation code. The lowest code is a full mute.

For each channel, software can ask that a new gain be held back until the channel's signal passes through midrail. This keeps gain changes from producing audible clicks. The block watches a signed sample stream per channel to find those crossings. A master-clock timeout forces a held update through if no crossing arrives. Software can switch that timeout off.

Software reaches the block through a simple write strobe with a 2-bit address and 8-bit data. The preamplifier itself is outside this block. So is applying the attenuation to samples: the block only produces the codes that drive them.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset both channels apply code 0xCF (0 dB), with nothing pending. The zero-cross enables are 0 and the timeout-disable bit is 0. The outputs are therefore preamp code 42, attenuation 0 and mute 0.
- R2: For an applied code c with c >= 0xA5, the preamp code is c - 0xA5 (0 = -21 dB, 90 = +24 dB, 0.5 dB per step), the attenuation is 0 and mute is 0.
- R3: For an applied code c in 0x01..0xA4, the preamp code is 0 (-21 dB), the attenuation is 0xA5 - c in 0.5 dB steps (1 for 0xA4, 164 for 0x01) and mute is 0.
- R4: Applied code 0x00 gives mute 1, preamp code 0 and attenuation 165.
- R5: Writes are decoded by wr_addr as follows. Address 0 writes the left gain and address 1 writes the right gain. Address 2 writes the control register, where bit 0 is the left zero-cross enable, bit 1 is the right zero-cross enable and bit 2 is the timeout disable. Address 3 writes nothing.
- R6: With the channel's zero-cross enable clear at the time of the write, the new gain appears on the outputs at the clock edge that samples the write.
- R7: With the channel's zero-cross enable set at the time of the write, the outputs keep the old gain. The new gain is applied at the edge that samples a valid sample on that channel that is either exactly zero or of opposite sign to that channel's previous valid sample. Samples without sample_valid are ignored.
- R8: With the timeout enabled and no crossing, a pending gain is applied exactly TIMEOUT_CYCLES clock edges after the edge that sampled its write.
- R9: With the timeout disabled, a pending gain waits for a crossing no matter how long it takes, and its timeout count is frozen.
- R10: A gain write to a channel with an update pending replaces the pending value and restarts the timeout count from zero.
- R11: Clearing a zero-cross enable does not release an update that is already pending.
- R12: The two channels are independent. Writes, samples and crossings on one channel do not change the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| sample_valid | input | 1 | Both sample inputs carry a new sample |
| sample_l | input | SAMPLE_W | Left signed sample |
| sample_r | input | SAMPLE_W | Right signed sample |
| pga_l | output | 7 | Left applied preamp code |
| att_l | output | 8 | Left digital attenuation, 0.5 dB steps |
| mute_l | output | 1 | Left mute |
| pga_r | output | 7 | Right applied preamp code |
| att_r | output | 8 | Right digital attenuation, 0.5 dB steps |
| mute_r | output | 1 | Right mute |

## Verification
The outputs are a combinational split of the applied code register. An immediate write therefore shows on the outputs just after the edge that samples it, and a crossing sample takes effect just after the edge that samples it. A timed-out update shows just after the TIMEOUT_CYCLES-th edge after the write. The bench drives every input on the falling edge and reads the outputs on the next falling edge, half a period after the edge in question. For the timeout it checks the old value one edge before the deadline and the new value at it. The bench runs with a short timeout so that the full code sweep and all the deferral cases fit in the run.

// File: rtl/gain_split_pkg.sv
package gain_split_pkg;

    localparam int CODE_W   = 8;
    localparam int PGA_W    = 7;
    localparam int ATT_W    = 8;

    localparam logic [CODE_W-1:0] CODE_UNITY   = 8'hCF;
    localparam logic [CODE_W-1:0] CODE_PGA_LOW = 8'hA5;
    localparam logic [ATT_W-1:0]  ATT_MUTE     = 8'd165;

    typedef enum logic [1:0] {
        REG_GAIN_L = 2'd0,
        REG_GAIN_R = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             mute;
        logic [PGA_W-1:0] pga;
        logic [ATT_W-1:0] att;
    } gain_split_t;

    function automatic gain_split_t split_gain(input logic [CODE_W-1:0] code);
        gain_split_t s;
        logic [CODE_W-1:0] diff;
        s = '0;
        if (code == '0) begin
            s.mute = 1'b1;
            s.att  = ATT_MUTE;
        end else if (code >= CODE_PGA_LOW) begin
            diff  = code - CODE_PGA_LOW;
            s.pga = diff[PGA_W-1:0];
        end else begin
            s.att = CODE_PGA_LOW - code;
        end
        return s;
    endfunction

endpackage

// File: rtl/zc_detect.sv
module zc_detect #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       crossing
);
    logic prev_sign;
    logic have_prev;
    logic cur_sign;
    logic is_zero;

    assign cur_sign = sample[SAMPLE_W-1];
    assign is_zero  = (sample == '0);
    assign crossing = valid && (is_zero || (have_prev && (cur_sign != prev_sign)));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sign <= 1'b0;
            have_prev <= 1'b0;
        end else if (valid) begin
            prev_sign <= cur_sign;
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/zc_gain_chan.sv
module zc_gain_chan
    import gain_split_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 131072
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_gain,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              zc_mode,
    input  logic              tmo_off,
    input  logic              crossing,
    output logic [CODE_W-1:0] applied,
    output logic              pending
);
    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CODE_W-1:0] held_code;
    logic [CNT_W-1:0]  wait_cnt;
    logic              expire;

    assign expire = !tmo_off && (wait_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            applied   <= CODE_UNITY;
            held_code <= CODE_UNITY;
            pending   <= 1'b0;
            wait_cnt  <= '0;
        end else if (wr_gain) begin
            wait_cnt <= '0;
            if (zc_mode) begin
                held_code <= wr_code;
                pending   <= 1'b1;
            end else begin
                applied <= wr_code;
                pending <= 1'b0;
            end
        end else if (pending) begin
            if (crossing || expire) begin
                applied  <= held_code;
                pending  <= 1'b0;
                wait_cnt <= '0;
            end else if (!tmo_off) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
    import gain_split_pkg::*;
#(
    parameter int SAMPLE_W       = 16,
    parameter int TIMEOUT_CYCLES = 131072
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_l,
    input  logic signed [SAMPLE_W-1:0] sample_r,
    output logic [6:0]                 pga_l,
    output logic [7:0]                 att_l,
    output logic                       mute_l,
    output logic [6:0]                 pga_r,
    output logic [7:0]                 att_r,
    output logic                       mute_r
);
    localparam int NCH = 2;

    logic [NCH-1:0] zc_en;
    logic           tmo_dis;
    logic [NCH-1:0] pending;
    logic [NCH-1:0] xing;
    logic [NCH-1:0] wr_gain;
    logic signed [SAMPLE_W-1:0] smp [NCH];
    logic [CODE_W-1:0] applied [NCH];
    gain_split_t       split_o [NCH];

    assign smp[0] = sample_l;
    assign smp[1] = sample_r;

    assign wr_gain[0] = wr_en && (reg_sel_e'(wr_addr) == REG_GAIN_L);
    assign wr_gain[1] = wr_en && (reg_sel_e'(wr_addr) == REG_GAIN_R);

    always_ff @(posedge clk) begin
        if (rst) begin
            zc_en   <= '0;
            tmo_dis <= 1'b0;
        end else if (wr_en && (reg_sel_e'(wr_addr) == REG_CTRL)) begin
            zc_en   <= wr_data[1:0];
            tmo_dis <= wr_data[2];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        zc_detect #(.SAMPLE_W(SAMPLE_W)) u_det (
            .clk      (clk),
            .rst      (rst),
            .valid    (sample_valid),
            .sample   (smp[i]),
            .crossing (xing[i])
        );

        zc_gain_chan #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_gain  (wr_gain[i]),
            .wr_code  (wr_data),
            .zc_mode  (zc_en[i]),
            .tmo_off  (tmo_dis),
            .crossing (xing[i]),
            .applied  (applied[i]),
            .pending  (pending[i])
        );

        assign split_o[i] = split_gain(applied[i]);
    end

    assign pga_l  = split_o[0].pga;
    assign att_l  = split_o[0].att;
    assign mute_l = split_o[0].mute;
    assign pga_r  = split_o[1].pga;
    assign att_r  = split_o[1].att;
    assign mute_r = split_o[1].mute;
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk
    import gain_split_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [1:0] zc_en,
    input logic [1:0] pending,
    input logic [1:0] xing,
    input logic [6:0] pga_l,
    input logic [7:0] att_l,
    input logic       mute_l,
    input logic [6:0] pga_r,
    input logic [7:0] att_r,
    input logic       mute_r
);
    logic [1:0]  wr_g;
    gain_split_t outs [2];

    assign wr_g[0] = wr_en && (wr_addr == 2'd0);
    assign wr_g[1] = wr_en && (wr_addr == 2'd1);
    assign outs[0] = {mute_l, pga_l, att_l};
    assign outs[1] = {mute_r, pga_r, att_r};

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R3
        attn_implies_pga_floor_chk: assert property (@(posedge clk) disable iff (rst)
            (outs[i].att != '0) |-> (outs[i].pga == '0));

        // R4
        mute_full_attn_chk: assert property (@(posedge clk) disable iff (rst)
            outs[i].mute |-> (outs[i].att == ATT_MUTE && outs[i].pga == '0));

        // R6
        direct_write_applies_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_g[i] && !zc_en[i]) |=> (outs[i] == split_gain($past(wr_data))));

        // R12
        idle_outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!pending[i] && !wr_g[i]) |=> $stable(outs[i]));

        // R7
        crossing_releases_chk: assert property (@(posedge clk) disable iff (rst)
            (pending[i] && xing[i] && !wr_g[i]) |=> !pending[i]);
    end
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .zc_en   (zc_en),
    .pending (pending),
    .xing    (xing),
    .pga_l   (pga_l),
    .att_l   (att_l),
    .mute_l  (mute_l),
    .pga_r   (pga_r),
    .att_r   (att_r),
    .mute_r  (mute_r)
);

// File: tb/zc_gain_ctrl_bench.sv
module zc_gain_ctrl_bench;
    localparam int SW  = 16;
    localparam int TMO = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic sample_valid = 1'b0;
    logic signed [SW-1:0] sample_l = 16'sd100;
    logic signed [SW-1:0] sample_r = 16'sd100;
    logic [6:0] pga_l, pga_r;
    logic [7:0] att_l, att_r;
    logic mute_l, mute_r;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    zc_gain_ctrl #(.SAMPLE_W(SW), .TIMEOUT_CYCLES(TMO)) u_zc_gain_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_valid(sample_valid), .sample_l(sample_l), .sample_r(sample_r),
        .pga_l(pga_l), .att_l(att_l), .mute_l(mute_l),
        .pga_r(pga_r), .att_r(att_r), .mute_r(mute_r)
    );

    function automatic logic [15:0] expect_of(input int code);
        int pga, att, mute;
        mute = (code == 0) ? 1 : 0;
        pga  = (code >= 165) ? code - 165 : 0;
        att  = (code == 0) ? 165 : ((code >= 165) ? 0 : 165 - code);
        return {mute[0], pga[6:0], att[7:0]};
    endfunction

    task automatic chk(input string req, input int ch, input int code);
        logic [15:0] got;
        logic [15:0] exp;
        got = (ch == 0) ? {mute_l, pga_l, att_l} : {mute_r, pga_r, att_r};
        exp = expect_of(code);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d got=%h expected=%h (code %h)", req, ch, got, exp, code[7:0]);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic smp(input int l, input int r, input bit v);
        @(negedge clk);
        sample_valid = v; sample_l = SW'(l); sample_r = SW'(r);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog got=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", 0, 8'hCF);
        chk("R1", 1, 8'hCF);

        // R2 R3 R4 R6: full sweep, zero-cross off, both channels
        for (int c = 0; c < 256; c++) begin
            wr(2'd0, 8'(c));
            chk((c == 0) ? "R4" : ((c >= 165) ? "R2" : "R3"), 0, c);
            wr(2'd1, 8'(255 - c));
            chk("R6", 1, 255 - c);
        end

        // R5: address 3 writes nothing
        wr(2'd0, 8'hB0);
        wr(2'd1, 8'h20);
        wr(2'd3, 8'h07);
        chk("R5", 0, 8'hB0);
        chk("R5", 1, 8'h20);
        wr(2'd1, 8'h21);
        chk("R5", 1, 8'h21);

        // R7: left deferred until sign change
        wr(2'd2, 8'h01);
        smp(100, 100, 1);
        wr(2'd0, 8'h80);
        chk("R7", 0, 8'hB0);
        smp(50, 100, 1);
        chk("R7", 0, 8'hB0);
        smp(-7, 100, 0);
        chk("R7", 0, 8'hB0);
        // R12: right is still immediate
        wr(2'd1, 8'h44);
        chk("R12", 1, 8'h44);
        chk("R12", 0, 8'hB0);
        smp(-7, 100, 1);
        chk("R7", 0, 8'h80);
        chk("R12", 1, 8'h44);

        // R7: exact zero sample counts
        wr(2'd0, 8'h10);
        smp(-3, 100, 1);
        chk("R7", 0, 8'h80);
        smp(0, 100, 1);
        chk("R7", 0, 8'h10);

        // R8: timeout at exactly TMO edges
        wr(2'd0, 8'h40);
        idle(TMO - 1);
        chk("R8", 0, 8'h10);
        idle(1);
        chk("R8", 0, 8'h40);

        // R10: rewrite restarts the count
        wr(2'd0, 8'h60);
        idle(20);
        wr(2'd0, 8'h50);
        idle(TMO - 1);
        chk("R10", 0, 8'h40);
        idle(1);
        chk("R10", 0, 8'h50);

        // R9: timeout disabled waits for a crossing
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h30);
        idle(3 * TMO);
        chk("R9", 0, 8'h50);
        smp(0, 100, 1);
        chk("R9", 0, 8'h30);

        // R11: clearing zero-cross enable keeps the pending update
        wr(2'd2, 8'h01);
        smp(20, 100, 1);
        wr(2'd0, 8'h22);
        wr(2'd2, 8'h00);
        chk("R11", 0, 8'h30);
        smp(-20, 100, 1);
        chk("R11", 0, 8'h22);
        wr(2'd0, 8'h23);
        chk("R11", 0, 8'h23);

        finish_run();
    end
endmodule